// File: doc/BRIEF.md
# Folded-Bus Lookahead Adder

This block adds two unsigned WIDTH-bit operands and produces a WIDTH+1-bit result. The work is split over WIDTH+1 cells, one per bit position plus one extra cell for the carry out. Each cell labels its operand bit pair with a 2-bit class. A bit pair whose two bits are both one is a carry source. A pair whose two bits are both zero absorbs any carry. A pair whose two bits differ passes a carry on.

All cells place their class codes on a folded pipelined bus. Each cell writes on the outgoing half of the bus and reads on the returning half. Every cell then sees the codes of all positions. Each cell finds its incoming carry by looking for the nearest lower position that does not pass a carry on. No ripple chain or lookahead tree is involved. The bus is modelled as one register per hop, so a whole trip through the fold costs 2*(WIDTH+1) clock cycles.

A caller pulses the start input with the operands valid. The done output pulses for one cycle once a fixed latency has passed. The result then stays on the sum output until the next result replaces it.

Top module: `folded_bus_adder`

## Requirements
- R1: While the synchronous active-high reset is applied, and in the first cycle after it is released, sum is 0 and done is 0.
- R2: A start sampled while no addition is in flight captures the operands. Done goes high for exactly one cycle, LAT = 2*(WIDTH+1)+1 rising edges after the edge that sampled start, and stays low at every other time.
- R3: When done is high, sum equals x+y as an unsigned WIDTH+1-bit value for the operands that were captured.
- R4: Each position is classed stop=2'b00 when both operand bits are 0, propagate=2'b01 when they differ, and generate=2'b10 when both are 1. The carry into position i is 1 exactly when the nearest lower position that is not propagate is a generate (for example 0xFF+0x01 gives 0x100).
- R5: When no lower position is generate or stop, the carry in is 0. Operands that differ in every bit give a sum of all ones with a top bit of 0 (0xA5+0x5A gives 0x0FF).
- R6: The carry into bit 0 is 0, so sum bit 0 is x[0] xor y[0].
- R7: A stop position absorbs the carry from a generate below it, so positions above the stop see carry 0 (0xC3+0x03 gives 0x0C6).
- R8: The top sum bit is the carry out of the most significant position (0xFF+0xFF gives 0x1FE).
- R9: A start sampled while an addition is in flight is ignored. This includes the edge on which done appears. Such a start produces no extra done pulse and leaves the pending result unchanged.
- R10: Outside a done pulse, sum holds its previous value whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an addition with the present operands |
| x | input | WIDTH | First operand, unsigned |
| y | input | WIDTH | Second operand, unsigned |
| sum | output | WIDTH+1 | Result including carry out |
| done | output | 1 | One-cycle pulse when sum is updated |

## Verification
A class code that is corrupted on any bus hop, or a carry search that picks the wrong lower position, appears as a wrong sum bit in the one cycle where done pulses. That is LAT edges after start, with no earlier sign at the ports. A fault in the hop counter shifts the done pulse away from edge LAT, repeats it, or drops it. A wrong busy flag shows up as an extra pulse or a replaced result after a start issued in mid-flight. Directed patterns for generate chains, stop barriers and all-propagate rows each target one carry case. Seeded random operands cover the rest.

// File: rtl/fbadd_pkg.sv
package fbadd_pkg;

  typedef enum logic [1:0] {
    CLS_STOP = 2'b00,
    CLS_PROP = 2'b01,
    CLS_GEN  = 2'b10
  } cellClass_e;

  typedef struct packed {
    logic load;
    logic finish;
  } addStrobe_t;

  function automatic logic [1:0] classify(input logic a, input logic b);
    return {a & b, a ^ b};
  endfunction

endpackage

// File: rtl/folded_add_ctrl.sv
module folded_add_ctrl
  import fbadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output addStrobe_t stb,
  output logic       done
);
  localparam int CELLS = WIDTH + 1;
  localparam int HOPS  = 2 * CELLS;
  localparam int CW    = $clog2(HOPS + 1);

  logic          busy;
  logic [CW-1:0] hopCnt;

  always_comb begin
    stb.load   = start && !busy;
    stb.finish = busy && (hopCnt == CW'(HOPS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      hopCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= stb.finish;
      if (stb.load) begin
        busy   <= 1'b1;
        hopCnt <= '0;
      end else if (busy) begin
        if (stb.finish) busy <= 1'b0;
        else            hopCnt <= hopCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/folded_add_path.sv
module folded_add_path
  import fbadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  addStrobe_t       stb,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH:0]   sum
);
  localparam int CELLS = WIDTH + 1;
  localparam int SEG   = CELLS;

  typedef logic [CELLS-1:0][1:0] busWord_t;

  logic [CELLS-1:0] xExt, yExt;
  busWord_t writeCodes, cellCodes, readCodes;
  busWord_t outSeg [SEG];
  busWord_t retSeg [SEG];
  logic [CELLS-1:0] carryIn;
  logic [WIDTH:0]   newSum;

  assign xExt = {1'b0, x};
  assign yExt = {1'b0, y};

  always_comb begin
    for (int i = 0; i < CELLS; i++) writeCodes[i] = classify(xExt[i], yExt[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)           cellCodes <= '0;
    else if (stb.load) cellCodes <= writeCodes;
  end

  for (genvar h = 0; h < SEG; h++) begin : g_hop
    always_ff @(posedge clk) begin
      if (rst) begin
        outSeg[h] <= '0;
        retSeg[h] <= '0;
      end else begin
        outSeg[h] <= (h == 0) ? cellCodes : outSeg[(h == 0) ? 0 : h - 1];
        retSeg[h] <= (h == 0) ? outSeg[SEG-1] : retSeg[(h == 0) ? 0 : h - 1];
      end
    end
  end

  assign readCodes = retSeg[SEG-1];

  always_comb begin
    for (int i = 0; i < CELLS; i++) begin
      carryIn[i] = 1'b0;
      for (int k = 0; k < i; k++) begin
        if (readCodes[k] != CLS_PROP) carryIn[i] = (readCodes[k] == CLS_GEN);
      end
      newSum[i] = readCodes[i][0] ^ carryIn[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             sum <= '0;
    else if (stb.finish) sum <= newSum;
  end
endmodule

// File: rtl/folded_bus_adder.sv
module folded_bus_adder
  import fbadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH:0]   sum,
  output logic             done
);
  addStrobe_t stb;

  folded_add_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .stb(stb), .done(done)
  );

  folded_add_path #(.WIDTH(WIDTH)) u_path (
    .clk(clk), .rst(rst), .stb(stb), .x(x), .y(y), .sum(sum)
  );
endmodule

// File: rtl/folded_bus_adder_chk.sv
module folded_bus_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [WIDTH-1:0] x,
  input logic [WIDTH-1:0] y,
  input logic [WIDTH:0]   sum,
  input logic             done
);
  localparam int LAT = 2 * (WIDTH + 1) + 1;
  localparam int AW  = $clog2(LAT + 1) + 1;

  logic           pend;
  logic [AW-1:0]  age;
  logic [WIDTH:0] expSum;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      age    <= '0;
      expSum <= '0;
    end else if (start && (!pend || done)) begin
      pend   <= 1'b1;
      age    <= '0;
      expSum <= {1'b0, x} + {1'b0, y};
    end else if (done) begin
      pend <= 1'b0;
    end else if (pend) begin
      age <= age + 1'b1;
    end
  end

  a_r2_done_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (pend && age == AW'(LAT)));
  a_r2_done_when_due: assert property (@(posedge clk) disable iff (rst)
    (pend && age == AW'(LAT)) |-> done);
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r3_sum_matches: assert property (@(posedge clk) disable iff (rst)
    done |-> (sum == expSum));
  a_r10_sum_holds: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(sum));
endmodule

bind folded_bus_adder folded_bus_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .start(start), .x(x), .y(y), .sum(sum), .done(done)
);

// File: tb/folded_bus_adder_test.sv
module folded_bus_adder_test;
  localparam int WIDTH  = 8;
  localparam int PERIOD = 10;
  localparam int LAT    = 2 * (WIDTH + 1) + 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [WIDTH-1:0] x = '0;
  logic [WIDTH-1:0] y = '0;
  logic [WIDTH:0]   sum;
  logic             done;
  int compared = 0;
  int mismatched = 0;

  always #(PERIOD/2) clk = ~clk;

  folded_bus_adder #(.WIDTH(WIDTH)) uut (
    .clk(clk), .rst(rst), .start(start), .x(x), .y(y), .sum(sum), .done(done)
  );

  function automatic logic [WIDTH:0] refAdd(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Drive start for one edge, then follow done through the latency window.
  task automatic runOp(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b, input string tag);
    int early = 0;
    x = a; y = b; start = 1'b1;
    tick();
    start = 1'b0;
    x = ~a; y = ~b;
    for (int k = 1; k < LAT; k++) begin
      tick();
      if (done) early++;
    end
    check("R2", "early done count", 32'(early), 32'd0);
    tick();
    check("R2", "done at latency", 32'(done), 32'd1);
    check(tag, "sum", 32'(sum), 32'(refAdd(a, b)));
    tick();
    check("R2", "done after pulse", 32'(done), 32'd0);
  endtask

  initial begin
    #(PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [WIDTH:0] held;
    void'($urandom(32'd4711));
    @(negedge clk);
    tick();
    check("R1", "sum in reset", 32'(sum), 32'd0);
    check("R1", "done in reset", 32'(done), 32'd0);
    rst = 1'b0;
    tick();
    check("R1", "sum after reset", 32'(sum), 32'd0);
    check("R1", "done after reset", 32'(done), 32'd0);

    runOp(8'h00, 8'h00, "R6");
    runOp(8'h01, 8'h00, "R6");
    runOp(8'hFF, 8'h01, "R4");
    runOp(8'h01, 8'h7F, "R4");
    runOp(8'hA5, 8'h5A, "R5");
    runOp(8'hFF, 8'h00, "R5");
    runOp(8'hC3, 8'h03, "R7");
    runOp(8'hFF, 8'hFF, "R8");
    runOp(8'h80, 8'h80, "R8");
    runOp(8'hAA, 8'hAA, "R4");
    runOp(8'h55, 8'hAA, "R5");

    // R10: sum holds while operands change and start stays low
    held = sum;
    for (int k = 0; k < 6; k++) begin
      x = 8'(k * 37); y = 8'(k * 91);
      tick();
    end
    check("R10", "held sum", 32'(sum), 32'(held));

    // R9: a start in mid-flight and on the done edge are both ignored
    begin
      int extra = 0;
      x = 8'h3C; y = 8'h0F; start = 1'b1;
      tick();
      start = 1'b0;
      for (int k = 1; k < LAT; k++) begin
        if (k == 4) begin x = 8'hFF; y = 8'hFF; start = 1'b1; end
        else start = 1'b0;
        tick();
      end
      x = 8'h11; y = 8'h22; start = 1'b1;
      tick();
      start = 1'b0;
      check("R9", "done despite mid start", 32'(done), 32'd1);
      check("R9", "sum keeps first operands", 32'(sum), 32'(refAdd(8'h3C, 8'h0F)));
      for (int k = 0; k < LAT + 3; k++) begin
        tick();
        if (done) extra++;
      end
      check("R9", "extra done count", 32'(extra), 32'd0);
      check("R9", "sum unchanged", 32'(sum), 32'(refAdd(8'h3C, 8'h0F)));
    end

    for (int n = 0; n < 40; n++) begin
      runOp(8'($urandom), 8'($urandom), "R3");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule